// File: doc/BRIEF.md
# UART Receive Queue with Trigger Control

This block buffers characters for the receive side of a 16550-class serial controller. A deserializer outside the block delivers each finished character together with three tags: bad parity, bad stop bit (framing) and line break. The block keeps these characters in arrival order. It shows the oldest one on the data read port at register offset 0. Reading offset 0 removes that character.

A write to register offset 2 sets the queue mode. Bit 0 switches between a 16-entry queue and a single holding register. Bit 1 empties the receive queue. Bit 2 asks the neighbouring transmit path to empty its queue. Bits 7:6 choose the receive trigger level. Any write that flips bit 0 empties both queues.

The block drives the receive-related bits of the line status byte. It also drives two indications for the interrupt logic. One says the fill level has reached the trigger. The other says characters below that level have been waiting for several character times.

Top module: `uart_rx_queue`

## Requirements
- R1: After a synchronous reset, `lsr` is 0x00, `rbr_data` is 0x00, and `fifo_mode`, `rx_trig`, `rx_timeout` and `tx_flush` are all 0.
- R2: A write to offset 2 loads bit 0 into `fifo_mode`. When bit 0 differs from the current `fifo_mode`, the receive queue is empty in the next cycle, and `tx_flush` is 1 for exactly that one cycle.
- R3: In a write to offset 2, bit 1 empties the receive queue by the next cycle. Bit 2 makes `tx_flush` high for one cycle and leaves receive data alone. Neither bit is stored, and neither acts on a later write.
- R4: Characters leave in arrival order. `rbr_data` shows the oldest stored character, or 0x00 when the queue is empty. A read at offset 0 removes that character. `lsr` bit 0 is 1 while at least one character is stored.
- R5: Capacity is 16 entries when `fifo_mode` is 1 and 1 entry when it is 0. A character that arrives while the queue is full is dropped, and the stored characters are kept. In that case `lsr` bit 1 (overrun) is set and stays set until a read at offset 5. A new overrun in the same cycle as that read wins.
- R6: `lsr` bit 2 is the parity tag, bit 3 the framing tag and bit 4 the break tag of the oldest stored character. These bits are 0 when the queue is empty. Bits 6:5 read 0.
- R7: `lsr` bit 7 is 1 while any stored character carries at least one of the three tags.
- R8: Bits 7:6 of the offset-2 write select a trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. In queue mode, `rx_trig` is 1 while the fill count is at or above that level. In holding-register mode, `rx_trig` is 1 while a character is stored.
- R9: In queue mode, `rx_timeout` rises when a character is stored and 4 `char_tick` pulses have arrived with no store, removal or flush since the last such event. Any of those events clears it. It is always 0 in holding-register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A finished character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity tag of the character |
| rx_ferr | input | 1 | Framing tag of the character |
| rx_brk | input | 1 | Break tag of the character |
| char_tick | input | 1 | One pulse per character time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read offset |
| rbr_data | output | 8 | Oldest stored character |
| lsr | output | 8 | Receive-related line status bits |
| fifo_mode | output | 1 | Queue mode is on |
| rx_trig | output | 1 | Fill count has reached the trigger level |
| rx_timeout | output | 1 | Data has been waiting without activity |
| tx_flush | output | 1 | One-cycle request to empty the transmit queue |

## Verification
Every stimulus takes effect at the first rising edge after it is applied. Stores, removals, flushes, overrun changes and the `tx_flush` pulse are all visible in the very next cycle. The bench therefore drives on a falling edge, lets one rising edge pass, and samples on the following falling edge. It checks `tx_flush` both in that cycle and one cycle later, to confirm the pulse lasts exactly one cycle. For the timeout, the bench counts `char_tick` pulses and expects the flag only after the fourth idle pulse. A scoreboard queue records the characters the bench expects to be accepted. Each removal is compared against the queue head, including the tags and the error summary bit.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int DATA_W = 8;
  localparam logic [2:0] ADDR_RBR = 3'd0;
  localparam logic [2:0] ADDR_FCR = 3'd2;
  localparam logic [2:0] ADDR_LSR = 3'd5;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              brk;
    logic              ferr;
    logic              perr;
  } rxq_entry_t;

  function automatic logic [31:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 32'd1;
      2'b01:   trig_level = 32'd4;
      2'b10:   trig_level = 32'd8;
      default: trig_level = 32'd14;
    endcase
  endfunction

  function automatic logic has_err(input rxq_entry_t e);
    has_err = e.perr | e.ferr | e.brk;
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_en,
  output logic [1:0]        trig_sel,
  output logic              rx_flush,
  output logic              tx_flush
);
  logic fcr_wr;
  logic toggle;

  assign fcr_wr   = wr_en && (wr_addr == ADDR_FCR);
  assign toggle   = fcr_wr && (wr_data[0] != fifo_en);
  assign rx_flush = toggle || (fcr_wr && wr_data[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'b00;
      tx_flush <= 1'b0;
    end else begin
      tx_flush <= toggle || (fcr_wr && wr_data[2]);
      if (fcr_wr) begin
        fifo_en  <= wr_data[0];
        trig_sel <= wr_data[7:6];
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       push,
  input  rxq_entry_t push_ent,
  input  logic       pop,
  input  logic [CW-1:0] cap,
  output rxq_entry_t head,
  output logic [CW-1:0] occ,
  output logic       err_any,
  output logic       accepted,
  output logic       removed
);
  rxq_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] err_cnt;
  logic          full;
  logic          in_err, out_err;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head     = mem[rd_ptr];
  assign full     = occ >= cap;
  assign removed  = pop && (occ != '0) && !flush;
  assign accepted = push && !flush && (!full || removed);
  assign in_err   = accepted && has_err(push_ent);
  assign out_err  = removed && has_err(head);
  assign err_any  = err_cnt != '0;

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      err_cnt <= '0;
    end else begin
      if (accepted) wr_ptr <= nxt(wr_ptr);
      if (removed)  rd_ptr <= nxt(rd_ptr);
      case ({accepted, removed})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      case ({in_err, out_err})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
  parameter int TO_CHARS = 4,
  localparam int IW = $clog2(TO_CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  input  logic has_data,
  input  logic tick,
  output logic expired
);
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || activity || !has_data) begin
      cnt <= '0;
    end else if (tick && (cnt != IW'(TO_CHARS))) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = has_data && (cnt == IW'(TO_CHARS));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       char_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rbr_data,
  output logic [7:0] lsr,
  output logic       fifo_mode,
  output logic       rx_trig,
  output logic       rx_timeout,
  output logic       tx_flush
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_flush;
  logic [1:0]    trig_sel;
  rxq_entry_t    in_ent, head;
  logic [CW-1:0] occ, cap;
  logic          err_any, accepted, removed;
  logic          ovr, has_data, idle_exp;
  logic          rbr_rd, lsr_rd;

  rxq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_en(fifo_mode), .trig_sel(trig_sel), .rx_flush(rx_flush),
    .tx_flush(tx_flush)
  );

  assign in_ent = '{data: rx_data, brk: rx_brk, ferr: rx_ferr, perr: rx_perr};
  assign cap    = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign rbr_rd = rd_en && (rd_addr == ADDR_RBR);
  assign lsr_rd = rd_en && (rd_addr == ADDR_LSR);

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_valid), .push_ent(in_ent),
    .pop(rbr_rd), .cap(cap), .head(head), .occ(occ), .err_any(err_any),
    .accepted(accepted), .removed(removed)
  );

  assign has_data = occ != '0;

  rxq_idle #(.TO_CHARS(TO_CHARS)) u_idle (
    .clk(clk), .rst(rst), .activity(accepted | removed | rx_flush),
    .has_data(has_data), .tick(char_tick), .expired(idle_exp)
  );

  always_ff @(posedge clk) begin
    if (rst)                                 ovr <= 1'b0;
    else if (rx_valid && !rx_flush && !accepted) ovr <= 1'b1;
    else if (lsr_rd)                         ovr <= 1'b0;
  end

  assign rbr_data   = has_data ? head.data : 8'h00;
  assign lsr        = {err_any, 2'b00,
                       has_data & head.brk, has_data & head.ferr,
                       has_data & head.perr, ovr, has_data};
  assign rx_trig    = fifo_mode ? ({{(32-CW){1'b0}}, occ} >= trig_level(trig_sel))
                                : has_data;
  assign rx_timeout = fifo_mode && idle_exp;
endmodule

// File: rtl/rxq_check.sv
module rxq_check
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          rd_en,
  input logic [2:0]    rd_addr,
  input logic [7:0]    lsr,
  input logic          fifo_mode,
  input logic          rx_trig,
  input logic          rx_timeout,
  input logic          tx_flush,
  input logic [CW-1:0] occ
);
  a_r2_toggle_flushes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_FCR && wr_data[0] != fifo_mode) |=> (!lsr[0] && tx_flush));

  a_r3_tx_clear_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_FCR && wr_data[2]) |=> tx_flush);

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (lsr[1] && !(rd_en && rd_addr == ADDR_LSR)) |=> lsr[1]);

  a_r5_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  a_r7_err_summary: assert property (@(posedge clk) disable iff (rst)
    (|lsr[4:2]) |-> lsr[7]);

  a_r8_trig_needs_data: assert property (@(posedge clk) disable iff (rst)
    rx_trig |-> lsr[0]);

  a_r9_timeout_scope: assert property (@(posedge clk) disable iff (rst)
    rx_timeout |-> (fifo_mode && lsr[0]));
endmodule

bind uart_rx_queue rxq_check #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .lsr(lsr), .fifo_mode(fifo_mode),
  .rx_trig(rx_trig), .rx_timeout(rx_timeout), .tx_flush(tx_flush), .occ(occ)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, char_tick = 0;
  logic [7:0] rx_data = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rbr_data, lsr;
  logic fifo_mode, rx_trig, rx_timeout, tx_flush;

  int checks = 0;
  int errors = 0;
  logic [10:0] exp_q[$];
  bit m_fifo = 0;
  bit m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .char_tick(char_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rbr_data(rbr_data), .lsr(lsr), .fifo_mode(fifo_mode),
    .rx_trig(rx_trig), .rx_timeout(rx_timeout), .tx_flush(tx_flush)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit any_err();
    foreach (exp_q[i]) if (|exp_q[i][2:0]) return 1'b1;
    return 1'b0;
  endfunction

  // Driver: presents a character and records it in the scoreboard when it fits.
  task automatic push(input logic [7:0] d, input logic [2:0] tags);
    int cap_m;
    cap_m = m_fifo ? 16 : 1;
    rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = tags;
    step();
    rx_valid = 0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
    if (exp_q.size() < cap_m) exp_q.push_back({d, tags});
    else m_ovr = 1;
    check("R5", "overrun bit", int'(lsr[1]), int'(m_ovr));
  endtask

  task automatic fcr(input logic [7:0] v);
    if (v[0] != m_fifo || v[1]) exp_q.delete();
    m_fifo = v[0];
    wr_en = 1; wr_addr = 3'd2; wr_data = v;
    step();
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1; rd_addr = a;
    step();
    rd_en = 0;
    if (a == 3'd5) m_ovr = 0;
  endtask

  task automatic tick();
    char_tick = 1;
    step();
    char_tick = 0;
  endtask

  // Monitor: compares the head against the scoreboard, then removes it.
  task automatic pop_check();
    logic [10:0] e;
    e = exp_q.pop_front();
    check("R4", "head data", rbr_data, e[10:3]);
    check("R6", "head tags", lsr[4:2], e[2:0]);
    rd(3'd0);
    check("R4", "data ready after read", int'(lsr[0]), int'(exp_q.size() != 0));
    check("R7", "error summary", int'(lsr[7]), int'(any_err()));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) pop_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    check("R1", "lsr", lsr, 8'h00);
    check("R1", "rbr", rbr_data, 8'h00);
    check("R1", "flags", {fifo_mode, rx_trig, rx_timeout, tx_flush}, 0);

    // R5 holding-register mode: capacity one, overrun keeps stored data
    push(8'h11, 3'b000);
    check("R8", "trig in holding mode", rx_trig, 1);
    push(8'h22, 3'b000);
    check("R5", "lsr after overrun", lsr, 8'h03);
    check("R5", "kept data", rbr_data, 8'h11);
    repeat (5) tick();
    check("R9", "no timeout in holding mode", rx_timeout, 0);
    rd(3'd5);
    check("R5", "overrun cleared by lsr read", lsr, 8'h01);
    pop_check();

    // R2 enable toggles: tx_flush pulses for exactly one cycle
    fcr(8'h01);
    check("R2", "fifo_mode", fifo_mode, 1);
    check("R2", "tx_flush pulse", tx_flush, 1);
    step();
    check("R2", "tx_flush one cycle", tx_flush, 0);

    // R8 trigger level 4
    fcr(8'h41);
    check("R2", "no flush without toggle", tx_flush, 0);
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i), 3'b000);
    check("R8", "below 4", rx_trig, 0);
    push(8'h33, 3'b000);
    check("R8", "at 4", rx_trig, 1);
    drain();

    // R8 trigger level 8
    fcr(8'h81);
    for (int i = 0; i < 7; i++) push(8'h40 + 8'(i), 3'b000);
    check("R8", "below 8", rx_trig, 0);
    push(8'h47, 3'b000);
    check("R8", "at 8", rx_trig, 1);
    drain();

    // R8 trigger level 14, then fill and overrun (R5)
    fcr(8'hC1);
    for (int i = 0; i < 13; i++) push(8'h50 + 8'(i), 3'b000);
    check("R8", "below 14", rx_trig, 0);
    push(8'h5D, 3'b000);
    check("R8", "at 14", rx_trig, 1);
    push(8'h5E, 3'b000);
    push(8'h5F, 3'b000);
    push(8'hEE, 3'b000);
    check("R5", "full overrun", lsr[1], 1);
    check("R5", "head kept", rbr_data, 8'h50);
    drain();
    check("R5", "overrun holds until lsr read", lsr[1], 1);
    rd(3'd5);
    check("R5", "overrun cleared", lsr[1], 0);

    // R6 R7 tags per entry and error summary
    push(8'h61, 3'b000);
    push(8'h62, 3'b001);
    push(8'h63, 3'b000);
    push(8'h64, 3'b110);
    push(8'h65, 3'b000);
    check("R7", "summary set", lsr[7], 1);
    check("R6", "bits 6:5 zero", lsr[6:5], 0);
    drain();
    check("R7", "summary clear", lsr[7], 0);

    // R3 receive clear and transmit clear
    push(8'h71, 3'b010);
    push(8'h72, 3'b000);
    push(8'h73, 3'b000);
    fcr(8'hC3);
    check("R3", "rx cleared", lsr, 8'h00);
    check("R3", "no tx flush on rx clear", tx_flush, 0);
    push(8'h74, 3'b000);
    push(8'h75, 3'b000);
    fcr(8'hC5);
    check("R3", "tx flush pulse", tx_flush, 1);
    check("R3", "rx data kept", lsr[0], 1);
    fcr(8'hC1);
    check("R3", "clear bit not stored", lsr[0], 1);
    drain();

    // R9 timeout after four idle character times
    fcr(8'h41);
    push(8'h81, 3'b000);
    for (int i = 0; i < 3; i++) tick();
    check("R9", "after 3 ticks", rx_timeout, 0);
    push(8'h82, 3'b000);
    for (int i = 0; i < 3; i++) tick();
    check("R9", "push restarts count", rx_timeout, 0);
    tick();
    check("R9", "after 4 idle ticks", rx_timeout, 1);
    pop_check();
    check("R9", "cleared by read", rx_timeout, 0);

    // R2 disabling flushes receive data
    push(8'h91, 3'b000);
    fcr(8'h00);
    check("R2", "flushed on disable", lsr[0], 0);
    check("R2", "tx flush on disable", tx_flush, 1);
    check("R2", "holding mode", fifo_mode, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule